// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block tracks instructions in flight in a speculative out-of-order core. Each instruction that issues claims one slot in a circular buffer and gets back a tag. Execution units later report results against that tag, in any order. The block retires slots only from the oldest end, one per cycle. A retiring slot either writes its destination register or releases a pending store to memory.

Because nothing leaves the buffer out of program order, architectural state never holds speculative results. When the oldest slot is a branch that was guessed wrong, every younger slot is discarded. When the oldest slot reports a fault, its commit is withheld and a trap is raised with the slot's program counter. The buffer is then cleared in the same way, which keeps interrupts precise.

Issue is gated by the buffer and by an external reservation-station free signal. Results arriving for slots that are not live are dropped.

Top module: `rob_inorder`

## Requirements
- R1: `alloc_ready` is high exactly when `rs_free` is high, no flush is being taken this cycle, and either fewer than DEPTH (8) slots are live or the oldest slot retires in this cycle. A slot is claimed when `alloc_valid` and `alloc_ready` are both high.
- R2: `alloc_tag` names the slot the next claim receives. It is 0 after reset and after every flush, and it advances by one, modulo DEPTH, on every claim.
- R3: A completion writes its value and flags into the live slot named by `cmp_tag`, whatever the order of completions. The oldest slot is not retired until it has been completed.
- R4: Retirement is in claim order, at most one per cycle. In the cycle after the oldest slot is completed without flags, one of two things happens, based on the kind code given at claim time:
  - kind 0 (register result) pulses `commit_reg_we` with the claimed `commit_dest` and the completed `commit_value`;
  - kind 1 (store) pulses `commit_store_go`;
  - kind 2 (branch) retires with neither pulse.
- R5: When the oldest slot is completed with `cmp_mispredict` set, nothing retires. `flush` pulses in the following cycle, all slots are emptied, and tags restart at 0. No younger slot ever retires.
- R6: When the oldest slot is completed with `cmp_exception` set, it does not retire. In the following cycle `trap_valid` and `flush` pulse together, and `trap_pc` carries the PC given when that slot was claimed. The exception takes precedence over a mispredict flag on the same slot.
- R7: A completion naming a slot that is not live changes no state. If that slot is claimed later, it still waits for its own completion before retiring.
- R8: When the buffer holds DEPTH slots and the oldest retires in this cycle, a claim in the same cycle is accepted.
- R9: In the cycle a flush is taken, any completion is dropped and no claim is accepted.
- R10: After reset no slot is live. `commit_reg_we`, `commit_store_go`, `flush` and `trap_valid` are low, and `alloc_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_free | input | 1 | A reservation-station slot is available |
| alloc_valid | input | 1 | An instruction asks to issue |
| alloc_kind | input | 2 | 0 register result, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register of the issuing instruction |
| alloc_pc | input | PC_W | Program counter of the issuing instruction |
| alloc_ready | output | 1 | Claim accepted this cycle if `alloc_valid` is high |
| alloc_tag | output | TAG_W | Tag given to the next claim |
| cmp_valid | input | 1 | A result is reported |
| cmp_tag | input | TAG_W | Slot the result belongs to |
| cmp_value | input | DATA_W | Result value |
| cmp_mispredict | input | 1 | Branch was guessed wrong |
| cmp_exception | input | 1 | Instruction faulted |
| commit_reg_we | output | 1 | Register write pulse from retirement |
| commit_dest | output | REG_W | Register written at retirement |
| commit_value | output | DATA_W | Value written at retirement |
| commit_store_go | output | 1 | Store released to memory |
| flush | output | 1 | All slots discarded |
| trap_valid | output | 1 | Faulting instruction reached the oldest slot |
| trap_pc | output | PC_W | PC of the faulting instruction |

## Verification
The bench finishes results out of order and confirms that the oldest slot holds back everything behind it. A design that retired on any completed slot would write registers out of program order. It also fills the buffer and then retires and claims in the same cycle. A design that decided fullness from the pointers alone, or refused that claim, would drop or double-issue tags. Mispredicts and faults are taken at the oldest slot while younger slots are already complete and a completion arrives in the flush cycle. Here a faulty design would commit squashed work, or it would leave a stale completion that lets a freshly claimed slot retire with no result. Completions aimed at dead slots check that such a write cannot mark a later occupant as finished.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] occ,
  output logic             full
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push) tail <= bump(tail);
      if (pop)  head <= bump(head);
      if (push && !pop)      occ <= occ + 1'b1;
      else if (pop && !push) occ <= occ - 1'b1;
    end
  end

  assign full = (occ == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_status.sv
module rob_status #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic [TAG_W-1:0] tail,
  input  logic             pop,
  input  logic [TAG_W-1:0] head,
  input  logic             cmp_we,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             cmp_mis,
  input  logic             cmp_exc,
  output logic [DEPTH-1:0] live_v,
  output logic [DEPTH-1:0] done_v,
  output logic [DEPTH-1:0] mis_v,
  output logic [DEPTH-1:0] exc_v
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        live_v[i] <= 1'b0;
        done_v[i] <= 1'b0;
        mis_v[i]  <= 1'b0;
        exc_v[i]  <= 1'b0;
      end else begin
        if (pop && head == TAG_W'(i)) live_v[i] <= 1'b0;
        if (push && tail == TAG_W'(i)) begin
          live_v[i] <= 1'b1;
          done_v[i] <= 1'b0;
          mis_v[i]  <= 1'b0;
          exc_v[i]  <= 1'b0;
        end
        if (cmp_we && cmp_tag == TAG_W'(i)) begin
          done_v[i] <= 1'b1;
          mis_v[i]  <= cmp_mis;
          exc_v[i]  <= cmp_exc;
        end
      end
    end
  end
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              wr_claim,
  input  logic [TAG_W-1:0]  claim_addr,
  input  logic [1:0]        claim_kind,
  input  logic [REG_W-1:0]  claim_dest,
  input  logic [PC_W-1:0]   claim_pc,
  input  logic              wr_result,
  input  logic [TAG_W-1:0]  result_addr,
  input  logic [DATA_W-1:0] result_value,
  input  logic [TAG_W-1:0]  rd_addr,
  output logic [1:0]        rd_kind,
  output logic [REG_W-1:0]  rd_dest,
  output logic [PC_W-1:0]   rd_pc,
  output logic [DATA_W-1:0] rd_value
);
  logic [1:0]        kind_mem [DEPTH];
  logic [REG_W-1:0]  dest_mem [DEPTH];
  logic [PC_W-1:0]   pc_mem   [DEPTH];
  logic [DATA_W-1:0] val_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_claim) begin
      kind_mem[claim_addr] <= claim_kind;
      dest_mem[claim_addr] <= claim_dest;
      pc_mem[claim_addr]   <= claim_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_result) val_mem[result_addr] <= result_value;
  end

  always_ff @(posedge clk) begin
    rd_kind  <= kind_mem[rd_addr];
    rd_dest  <= dest_mem[rd_addr];
    rd_pc    <= pc_mem[rd_addr];
    rd_value <= val_mem[rd_addr];
  end
endmodule

// File: rtl/rob_inorder.sv
module rob_inorder #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rs_free,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_mispredict,
  input  logic              cmp_exception,
  output logic              commit_reg_we,
  output logic [REG_W-1:0]  commit_dest,
  output logic [DATA_W-1:0] commit_value,
  output logic              commit_store_go,
  output logic              flush,
  output logic              trap_valid,
  output logic [PC_W-1:0]   trap_pc
);
  import rob_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] occ;
  logic             full;
  logic [DEPTH-1:0] live_v, done_v, mis_v, exc_v;
  logic             head_done, head_bad, take_flush, retire, push, cmp_take;
  logic             retire_q, flush_q, trap_q;
  logic [1:0]       rd_kind;

  // Decisions taken at the oldest slot
  assign head_done  = live_v[head] && done_v[head];
  assign head_bad   = mis_v[head] || exc_v[head];
  assign take_flush = head_done && head_bad;
  assign retire     = head_done && !head_bad;

  assign alloc_ready = rs_free && !take_flush && (!full || retire);
  assign push        = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;
  assign cmp_take    = cmp_valid && live_v[cmp_tag] && !take_flush &&
                       !(retire && cmp_tag == head);

  rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst(rst), .clear(take_flush), .push(push), .pop(retire),
    .head(head), .tail(tail), .occ(occ), .full(full)
  );

  rob_status #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_status (
    .clk(clk), .rst(rst), .clear(take_flush),
    .push(push), .tail(tail), .pop(retire), .head(head),
    .cmp_we(cmp_take), .cmp_tag(cmp_tag),
    .cmp_mis(cmp_mispredict), .cmp_exc(cmp_exception),
    .live_v(live_v), .done_v(done_v), .mis_v(mis_v), .exc_v(exc_v)
  );

  rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W),
              .REG_W(REG_W), .PC_W(PC_W)) u_store (
    .clk(clk),
    .wr_claim(push), .claim_addr(tail), .claim_kind(alloc_kind),
    .claim_dest(alloc_dest), .claim_pc(alloc_pc),
    .wr_result(cmp_take), .result_addr(cmp_tag), .result_value(cmp_value),
    .rd_addr(head),
    .rd_kind(rd_kind), .rd_dest(commit_dest), .rd_pc(trap_pc),
    .rd_value(commit_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      retire_q <= 1'b0;
      flush_q  <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      retire_q <= retire;
      flush_q  <= take_flush;
      trap_q   <= take_flush && exc_v[head];
    end
  end

  assign commit_reg_we   = retire_q && (rd_kind == KIND_ALU);
  assign commit_store_go = retire_q && (rd_kind == KIND_STORE);
  assign flush           = flush_q;
  assign trap_valid      = trap_q;
endmodule

// File: rtl/rob_inorder_checker.sv
module rob_inorder_checker #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rs_free,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             commit_reg_we,
  input logic             commit_store_go,
  input logic             flush,
  input logic             trap_valid,
  input logic [CNT_W-1:0] occ
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  assert_gate_by_rs_R1: assert property (@(posedge clk) disable iff (rst)
    alloc_ready |-> rs_free);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  assert_tag_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready) |=>
      (alloc_tag == (($past(alloc_tag) == LAST) ? '0 : $past(alloc_tag) + 1'b1)));

  assert_single_action_R4: assert property (@(posedge clk) disable iff (rst)
    !(commit_reg_we && commit_store_go));

  assert_tag_restart_R5: assert property (@(posedge clk) disable iff (rst)
    flush |-> (alloc_tag == '0 && occ == '0));

  assert_quiet_after_flush_R5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!commit_reg_we && !commit_store_go));

  assert_trap_flushes_R6: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> flush);

  assert_no_retire_with_flush_R5: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!commit_reg_we && !commit_store_go));
endmodule

bind rob_inorder rob_inorder_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .rs_free(rs_free), .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .commit_reg_we(commit_reg_we), .commit_store_go(commit_store_go),
  .flush(flush), .trap_valid(trap_valid), .occ(occ)
);

// File: tb/rob_inorder_test.sv
`timescale 1ns/1ps
module rob_inorder_test;
  localparam int DEPTH = 8, TAG_W = 3, DATA_W = 32, REG_W = 5, PC_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic rs_free = 1'b0, alloc_valid = 1'b0;
  logic [1:0] alloc_kind = '0;
  logic [REG_W-1:0] alloc_dest = '0;
  logic [PC_W-1:0] alloc_pc = '0;
  logic alloc_ready;
  logic [TAG_W-1:0] alloc_tag;
  logic cmp_valid = 1'b0;
  logic [TAG_W-1:0] cmp_tag = '0;
  logic [DATA_W-1:0] cmp_value = '0;
  logic cmp_mispredict = 1'b0, cmp_exception = 1'b0;
  logic commit_reg_we, commit_store_go, flush, trap_valid;
  logic [REG_W-1:0] commit_dest;
  logic [DATA_W-1:0] commit_value;
  logic [PC_W-1:0] trap_pc;

  rob_inorder uut (
    .clk(clk), .rst(rst), .rs_free(rs_free), .alloc_valid(alloc_valid),
    .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .cmp_mispredict(cmp_mispredict), .cmp_exception(cmp_exception),
    .commit_reg_we(commit_reg_we), .commit_dest(commit_dest),
    .commit_value(commit_value), .commit_store_go(commit_store_go),
    .flush(flush), .trap_valid(trap_valid), .trap_pc(trap_pc)
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  // Reference model, indexed by tag
  logic m_live [DEPTH];
  logic m_done [DEPTH];
  logic m_mis  [DEPTH];
  logic m_exc  [DEPTH];
  logic [1:0] m_kind [DEPTH];
  logic [REG_W-1:0] m_dest [DEPTH];
  logic [DATA_W-1:0] m_val [DEPTH];
  logic [PC_W-1:0] m_pc [DEPTH];
  int m_head = 0, m_tail = 0, m_count = 0;

  // Expected registered outputs for the next sample
  logic e_we = 0, e_st = 0, e_fl = 0, e_trap = 0;
  logic [REG_W-1:0] e_dest = '0;
  logic [DATA_W-1:0] e_val = '0;
  logic [PC_W-1:0] e_pc = '0;
  string phase = "reset";

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s (%s): actual %0h expected %0h", req, what, phase, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_live[i] = 0; m_done[i] = 0; m_mis[i] = 0; m_exc[i] = 0;
    end
    m_head = 0; m_tail = 0; m_count = 0;
  endtask

  task automatic check_outputs();
    chk("R4", "commit_reg_we", 64'(commit_reg_we), 64'(e_we));
    if (e_we) begin
      chk("R4", "commit_dest", 64'(commit_dest), 64'(e_dest));
      chk("R4", "commit_value", 64'(commit_value), 64'(e_val));
    end
    chk("R4", "commit_store_go", 64'(commit_store_go), 64'(e_st));
    chk("R5", "flush", 64'(flush), 64'(e_fl));
    chk("R6", "trap_valid", 64'(trap_valid), 64'(e_trap));
    if (e_trap) chk("R6", "trap_pc", 64'(trap_pc), 64'(e_pc));
  endtask

  task automatic step(input logic av, input logic [1:0] k, input logic [REG_W-1:0] d,
                      input logic [PC_W-1:0] pc, input logic rsf,
                      input logic cv, input logic [TAG_W-1:0] ct,
                      input logic [DATA_W-1:0] cval, input logic cm, input logic ce);
    int h;
    logic hd, fl, rt, exp_rdy, fire;
    string rq;
    @(negedge clk);
    check_outputs();
    alloc_valid = av; alloc_kind = k; alloc_dest = d; alloc_pc = pc; rs_free = rsf;
    cmp_valid = cv; cmp_tag = ct; cmp_value = cval; cmp_mispredict = cm; cmp_exception = ce;
    #1;
    h  = m_head;
    hd = (m_count > 0) && m_done[h];
    fl = hd && (m_mis[h] || m_exc[h]);
    rt = hd && !fl;
    exp_rdy = rsf && !fl && ((m_count < DEPTH) || rt);
    rq = fl ? "R9" : ((m_count == DEPTH && rt) ? "R8" : "R1");
    chk(rq, "alloc_ready", 64'(alloc_ready), 64'(exp_rdy));
    chk("R2", "alloc_tag", 64'(alloc_tag), 64'(m_tail));
    e_we   = rt && (m_kind[h] == 2'd0);
    e_st   = rt && (m_kind[h] == 2'd1);
    e_dest = m_dest[h];
    e_val  = m_val[h];
    e_fl   = fl;
    e_trap = fl && m_exc[h];
    e_pc   = m_pc[h];
    fire   = av && exp_rdy;
    if (fl) model_clear();   // R9: completion and claim both dropped
    else begin
      // R7: only live slots, and not the one retiring now, take a completion
      if (cv && m_live[ct] && !(rt && int'(ct) == h)) begin
        m_done[ct] = 1; m_mis[ct] = cm; m_exc[ct] = ce; m_val[ct] = cval;
      end
      if (rt) begin m_live[h] = 0; m_head = nxt(h); m_count--; end
      if (fire) begin
        m_live[m_tail] = 1; m_done[m_tail] = 0; m_mis[m_tail] = 0; m_exc[m_tail] = 0;
        m_kind[m_tail] = k; m_dest[m_tail] = d; m_pc[m_tail] = pc;
        m_tail = nxt(m_tail); m_count++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask
  task automatic claim(input logic [1:0] k, input logic [REG_W-1:0] d, input logic [PC_W-1:0] pc);
    step(1, k, d, pc, 1, 0, 0, 0, 0, 0);
  endtask
  task automatic finish_slot(input int t, input logic [DATA_W-1:0] v, input logic cm, input logic ce);
    step(0, 0, 0, 0, 1, 1, TAG_W'(t), v, cm, ce);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'h1f2e3d4c));
    model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_kind[i] = 0; m_dest[i] = 0; m_val[i] = 0; m_pc[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state held by reset
    chk("R10", "commit_reg_we", 64'(commit_reg_we), 0);
    chk("R10", "commit_store_go", 64'(commit_store_go), 0);
    chk("R10", "flush", 64'(flush), 0);
    chk("R10", "trap_valid", 64'(trap_valid), 0);
    chk("R10", "alloc_tag", 64'(alloc_tag), 0);
    rst = 1'b0;

    phase = "R3 out-of-order completion";
    claim(0, 5'd1, 32'h100); claim(1, 5'd2, 32'h104); claim(0, 5'd3, 32'h108);
    finish_slot(2, 32'hc2, 0, 0); finish_slot(1, 32'hb1, 0, 0);
    idle(2);
    finish_slot(0, 32'ha0, 0, 0);
    idle(5);

    phase = "R1 fill to capacity";
    for (int i = 0; i < DEPTH; i++) claim(0, 5'(i + 8), 32'h200 + 32'(i * 4));
    claim(0, 5'd30, 32'h2ff);
    step(1, 0, 5'd30, 32'h2fe, 0, 0, 0, 0, 0, 0);

    phase = "R8 retire and refill while full";
    finish_slot(m_head, 32'h5a5a, 0, 0);
    claim(1, 5'd17, 32'h300);
    for (int i = 0; i < DEPTH; i++) finish_slot((m_head + DEPTH - 1 - i) % DEPTH, 32'(i + 32'h40), 0, 0);
    idle(DEPTH + 3);

    phase = "R7 completion to dead slot";
    t0 = (m_tail + 2) % DEPTH;
    finish_slot(t0, 32'hdead, 0, 0);
    for (int i = 0; i < 4; i++) claim(0, 5'(i + 20), 32'h400 + 32'(i));
    finish_slot((t0 + DEPTH - 2) % DEPTH, 32'h11, 0, 0);
    finish_slot((t0 + DEPTH - 1) % DEPTH, 32'h22, 0, 0);
    idle(4);
    finish_slot(t0, 32'h33, 0, 0);
    finish_slot((t0 + 1) % DEPTH, 32'h44, 0, 0);
    idle(4);

    phase = "R5 R9 mispredict at head";
    t0 = m_tail;
    claim(2, 5'd0, 32'h500); claim(0, 5'd6, 32'h504); claim(1, 5'd7, 32'h508);
    finish_slot((t0 + 1) % DEPTH, 32'h66, 0, 0);
    finish_slot((t0 + 2) % DEPTH, 32'h77, 0, 0);
    finish_slot(t0, 32'h0, 1, 0);
    step(1, 0, 5'd9, 32'h50c, 1, 1, TAG_W'((t0 + 1) % DEPTH), 32'h99, 0, 0);
    claim(0, 5'd10, 32'h510);
    idle(3);
    finish_slot(0, 32'h1234, 0, 0);
    idle(3);

    phase = "R6 fault at head";
    claim(0, 5'd12, 32'h600); claim(0, 5'd13, 32'h604);
    finish_slot(m_head + 1, 32'h13, 0, 0);
    finish_slot(m_head, 32'h12, 1, 1);
    idle(3);

    phase = "random";
    for (int n = 0; n < 4000; n++) begin
      logic av, rsf, cv, cm, ce;
      int ct;
      av  = ($urandom % 10) < 7;
      rsf = ($urandom % 10) < 8;
      cv  = ($urandom % 10) < 6;
      if (m_count > 0 && ($urandom % 10) < 8) ct = (m_head + int'($urandom % m_count)) % DEPTH;
      else ct = int'($urandom % DEPTH);
      cm = ($urandom % 25) == 0;
      ce = ($urandom % 50) == 0;
      step(av, 2'($urandom % 3), 5'($urandom), $urandom, rsf,
           cv, TAG_W'(ct), $urandom, cm, ce);
    end
    idle(4);
    @(negedge clk);
    check_outputs();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule